// File: doc/BRIEF.md
# Instruction Prefix Collector

This block sits at the front of an instruction decode path and receives instruction bytes one at a time. While the bytes are prefixes, it records them. Segment selection, lock, the two repeat forms and the address-size and operand-size overrides are packed into a single byte-wide prefix vector. In long (64-bit) mode, a byte in the range 0x40 to 0x4F is taken as a register-extension prefix, and its low four bits are kept as separate W, R, X and B fields.

The first byte that is not a prefix is taken as the opcode. On that same clock edge, the block latches the opcode and resolves an effective operand-size code from three inputs: the mode input, the extension W bit and the operand-size override. It also raises a done strobe for exactly one cycle. After that, the block ignores further bytes until the surrounding logic pulses `clear` to begin the next instruction.

Top module: `prefix_gather`

## Requirements
- R1: After reset, and in the cycle after `clear` is sampled high, every output is zero: `pfx_vec`, `rex_seen`, `rex_bits`, `opcode`, `op_size` and `done`. `clear` takes priority over a byte presented in the same cycle.
- R2: The flag prefixes set single bits of `pfx_vec`: 0xF2 sets bit 7, 0xF3 sets bit 6, 0xF0 sets bit 5, 0x67 sets bit 4 and 0x66 sets bit 3. A repeated flag prefix leaves its bit set and changes no other bit.
- R3: `pfx_vec[2:0]` holds a segment code: 0 for none, 1 for 0x2E, 2 for 0x3E, 3 for 0x26, 4 for 0x64, 5 for 0x65 and 6 for 0x36. When several segment prefixes arrive, the most recent one replaces the code.
- R4: The `mode` input is encoded as 0 for long mode, 1 for 32-bit default and 2 or 3 for 16-bit default. Only when `mode` is 0 is a byte in 0x40–0x4F an extension prefix; it sets `rex_seen` and loads `rex_bits` with {W,R,X,B} from bits 3:0. In any other mode such a byte is the opcode.
- R5: The first accepted byte that is not a prefix appears on `opcode`, and `done` goes high after that same clock edge. `done` stays high for exactly one cycle.
- R6: In long mode, `op_size` is 3 when the extension prefix was seen with W=1. Otherwise it is 1 if 0x66 was seen, and 2 if it was not.
- R7: In 32-bit default mode, `op_size` is 1 if 0x66 was seen and 2 if it was not.
- R8: In 16-bit default mode, `op_size` is 2 if 0x66 was seen and 1 if it was not.
- R9: Once the opcode is taken, further bytes leave every output unchanged until `clear`. A cycle with `byte_valid` low also changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Start a new instruction (wipe collected state) |
| byte_valid | input | 1 | `byte_in` carries an instruction byte this cycle |
| byte_in | input | 8 | Instruction byte |
| mode | input | 2 | 0 long, 1 32-bit default, 2/3 16-bit default |
| pfx_vec | output | 8 | Packed prefix vector (flags 7:3, segment code 2:0) |
| rex_seen | output | 1 | Extension prefix was received |
| rex_bits | output | 4 | Extension fields {W,R,X,B} |
| opcode | output | 8 | Latched opcode byte |
| op_size | output | 2 | Operand size code: 1=16, 2=32, 3=64, 0 before opcode |
| done | output | 1 | One-cycle strobe when the opcode is latched |

## Verification
Every result is registered once. A prefix byte accepted at an edge shows up in `pfx_vec` or `rex_bits` right after that edge. The opcode, `op_size` and a high `done` likewise appear right after the edge that accepts the opcode, and `done` falls after the following edge. The bench drives inputs on the falling edge and compares all outputs at the next falling edge, so each comparison falls exactly one register stage after its stimulus. The extra one-cycle check on `done`, and the checks on bytes sent after the opcode, use the same sampling point.

// File: rtl/pfx_pkg.sv
// Package: shared widths, encodings and byte classes for the prefix collector.
// Assumes byte-serial input; bit positions here are decoded by downstream logic.
package pfx_pkg;

    localparam int BYTE_W  = 8;
    localparam int VEC_W   = 8;
    localparam int SEG_W   = 3;
    localparam int REX_W   = 4;
    localparam int SIZE_W  = 2;
    localparam int MODE_W  = 2;

    // prefix vector bit positions
    localparam int POS_REPNE = 7;
    localparam int POS_REP   = 6;
    localparam int POS_LOCK  = 5;
    localparam int POS_ADSZ  = 4;
    localparam int POS_OPSZ  = 3;

    localparam logic [MODE_W-1:0] MODE_LONG  = 2'd0;
    localparam logic [MODE_W-1:0] MODE_DEF32 = 2'd1;

    localparam logic [SIZE_W-1:0] SZ_NONE = 2'd0;
    localparam logic [SIZE_W-1:0] SZ_16   = 2'd1;
    localparam logic [SIZE_W-1:0] SZ_32   = 2'd2;
    localparam logic [SIZE_W-1:0] SZ_64   = 2'd3;

    typedef enum logic [SEG_W-1:0] {
        SEG_NONE = 3'd0, SEG_CS = 3'd1, SEG_DS = 3'd2, SEG_ES = 3'd3,
        SEG_FS = 3'd4, SEG_GS = 3'd5, SEG_SS = 3'd6
    } seg_code_e;

    typedef enum logic [2:0] {
        BK_OPCODE, BK_SEG, BK_OPSZ, BK_ADSZ, BK_LOCK, BK_REP, BK_REPNE, BK_REX
    } byte_kind_e;

endpackage

// File: rtl/pfx_classify.sv
// Module: pfx_classify
// Purely combinational sort of one instruction byte into a prefix class.
// Assumes the extension range is honoured only when long_mode is high.
module pfx_classify
    import pfx_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic [BW-1:0]    byte_in,
    input  logic             long_mode,
    output byte_kind_e       kind,
    output logic [SEG_W-1:0] seg_code
);

    // Map the byte value to its class and segment code.
    always_comb begin
        kind     = BK_OPCODE;
        seg_code = SEG_NONE;
        case (byte_in[7:0])
            8'h2E: begin kind = BK_SEG; seg_code = SEG_CS; end
            8'h3E: begin kind = BK_SEG; seg_code = SEG_DS; end
            8'h26: begin kind = BK_SEG; seg_code = SEG_ES; end
            8'h64: begin kind = BK_SEG; seg_code = SEG_FS; end
            8'h65: begin kind = BK_SEG; seg_code = SEG_GS; end
            8'h36: begin kind = BK_SEG; seg_code = SEG_SS; end
            8'h66: kind = BK_OPSZ;
            8'h67: kind = BK_ADSZ;
            8'hF0: kind = BK_LOCK;
            8'hF3: kind = BK_REP;
            8'hF2: kind = BK_REPNE;
            default: begin
                if (long_mode && byte_in[7:4] == 4'h4)
                    kind = BK_REX;
            end
        endcase
    end

endmodule

// File: rtl/pfx_size_resolve.sv
// Module: pfx_size_resolve
// Combinational operand-size resolution from mode, extension W and override.
// Assumes mode codes 2 and 3 both mean a 16-bit default.
module pfx_size_resolve
    import pfx_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              rex_w,
    input  logic              opsz_ovr,
    output logic [SIZE_W-1:0] size_code
);

    // Choose the size code per mode.
    always_comb begin
        if (mode == MODE_LONG)
            size_code = rex_w ? SZ_64 : (opsz_ovr ? SZ_16 : SZ_32);
        else if (mode == MODE_DEF32)
            size_code = opsz_ovr ? SZ_16 : SZ_32;
        else
            size_code = opsz_ovr ? SZ_32 : SZ_16;
    end

endmodule

// File: rtl/pfx_accum.sv
// Module: pfx_accum
// State registers: folds classified bytes into the prefix vector and
// extension fields, latches the opcode and size, and marks completion.
// Assumes the size input is valid in the cycle the opcode byte is accepted.
module pfx_accum
    import pfx_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              byte_valid,
    input  logic [BW-1:0]     byte_in,
    input  byte_kind_e        kind,
    input  logic [SEG_W-1:0]  seg_code,
    input  logic [SIZE_W-1:0] size_in,
    output logic [VEC_W-1:0]  vec_q,
    output logic              rex_seen_q,
    output logic [REX_W-1:0]  rex_q,
    output logic [BW-1:0]     opcode_q,
    output logic [SIZE_W-1:0] size_q,
    output logic              done_q,
    output logic              fin_q
);

    // Accumulate prefixes until the opcode, then hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vec_q      <= '0;
            rex_seen_q <= 1'b0;
            rex_q      <= '0;
            opcode_q   <= '0;
            size_q     <= SZ_NONE;
            done_q     <= 1'b0;
            fin_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (byte_valid && !fin_q) begin
                case (kind)
                    BK_SEG:   vec_q[SEG_W-1:0] <= seg_code;
                    BK_OPSZ:  vec_q[POS_OPSZ]  <= 1'b1;
                    BK_ADSZ:  vec_q[POS_ADSZ]  <= 1'b1;
                    BK_LOCK:  vec_q[POS_LOCK]  <= 1'b1;
                    BK_REP:   vec_q[POS_REP]   <= 1'b1;
                    BK_REPNE: vec_q[POS_REPNE] <= 1'b1;
                    BK_REX: begin
                        rex_seen_q <= 1'b1;
                        rex_q      <= byte_in[REX_W-1:0];
                    end
                    default: begin
                        opcode_q <= byte_in;
                        size_q   <= size_in;
                        done_q   <= 1'b1;
                        fin_q    <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/prefix_gather.sv
// Module: prefix_gather (top)
// Byte-serial prefix collector: wires the classifier, size resolver and
// state registers. Assumes mode is steady while an instruction streams in.
module prefix_gather
    import pfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic [1:0]        mode,
    output logic [7:0]        pfx_vec,
    output logic              rex_seen,
    output logic [3:0]        rex_bits,
    output logic [7:0]        opcode,
    output logic [1:0]        op_size,
    output logic              done
);

    byte_kind_e        kind_w;
    logic [SEG_W-1:0]  seg_w;
    logic [SIZE_W-1:0] size_w;
    logic              fin_w;

    pfx_classify #(.BW(BYTE_W)) u_cls (
        .byte_in   (byte_in),
        .long_mode (mode == MODE_LONG),
        .kind      (kind_w),
        .seg_code  (seg_w)
    );

    pfx_size_resolve u_size (
        .mode      (mode),
        .rex_w     (rex_seen & rex_bits[3]),
        .opsz_ovr  (pfx_vec[POS_OPSZ]),
        .size_code (size_w)
    );

    pfx_accum #(.BW(BYTE_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .kind       (kind_w),
        .seg_code   (seg_w),
        .size_in    (size_w),
        .vec_q      (pfx_vec),
        .rex_seen_q (rex_seen),
        .rex_q      (rex_bits),
        .opcode_q   (opcode),
        .size_q     (op_size),
        .done_q     (done),
        .fin_q      (fin_w)
    );

endmodule

// File: rtl/pfx_gather_chk.sv
// Module: pfx_gather_chk
// Protocol checker bound to prefix_gather; observes ports and the
// completion flag only.
module pfx_gather_chk (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       byte_valid,
    input  logic [1:0] mode,
    input  logic [7:0] pfx_vec,
    input  logic       rex_seen,
    input  logic [3:0] rex_bits,
    input  logic [7:0] opcode,
    input  logic [1:0] op_size,
    input  logic       done,
    input  logic       fin
);

    assert_clear_wipes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pfx_vec == 8'd0 && !rex_seen && op_size == 2'd0 && !done));

    assert_seg_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_vec[2:0] != 3'd7);

    assert_rex_long_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rex_seen) |-> $past(mode) == 2'd0);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_sized_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> op_size != 2'd0);

    assert_hold_after_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !clear) |=> ($stable(pfx_vec) && $stable(opcode) &&
                             $stable(op_size) && $stable(rex_bits)));

endmodule

bind prefix_gather pfx_gather_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .byte_valid (byte_valid),
    .mode       (mode),
    .pfx_vec    (pfx_vec),
    .rex_seen   (rex_seen),
    .rex_bits   (rex_bits),
    .opcode     (opcode),
    .op_size    (op_size),
    .done       (done),
    .fin        (fin_w)
);

// File: tb/sim_prefix_gather.sv
module sim_prefix_gather;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'd0;
    logic [1:0] mode = 2'd0;
    logic [7:0] pfx_vec;
    logic       rex_seen;
    logic [3:0] rex_bits;
    logic [7:0] opcode;
    logic [1:0] op_size;
    logic       done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // expected state
    logic [7:0] e_vec;
    logic       e_rs;
    logic [3:0] e_rex;
    logic [7:0] e_op;
    logic [1:0] e_sz;
    logic       e_done;
    logic       e_fin;

    always #2 clk = ~clk;

    prefix_gather u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .byte_valid(byte_valid),
        .byte_in(byte_in), .mode(mode), .pfx_vec(pfx_vec), .rex_seen(rex_seen),
        .rex_bits(rex_bits), .opcode(opcode), .op_size(op_size), .done(done)
    );

    function automatic logic [1:0] exp_size(input logic [1:0] m, input logic w,
                                            input logic ovr);
        if (m == 2'd0) return w ? 2'd3 : (ovr ? 2'd1 : 2'd2); // R6
        if (m == 2'd1) return ovr ? 2'd1 : 2'd2;              // R7
        return ovr ? 2'd2 : 2'd1;                             // R8
    endfunction

    function automatic bit is_prefix(input logic [7:0] b, input logic [1:0] m);
        case (b)
            8'h2E, 8'h3E, 8'h26, 8'h64, 8'h65, 8'h36,
            8'h66, 8'h67, 8'hF0, 8'hF3, 8'hF2: return 1'b1;
            default: return (m == 2'd0 && b[7:4] == 4'h4);
        endcase
    endfunction

    task automatic model(input logic v, input logic [7:0] b, input logic clr);
        if (clr) begin
            e_vec = 0; e_rs = 0; e_rex = 0; e_op = 0; e_sz = 0; e_done = 0; e_fin = 0;
        end else begin
            e_done = 0;
            if (v && !e_fin) begin
                case (b)
                    8'h2E: e_vec[2:0] = 3'd1;
                    8'h3E: e_vec[2:0] = 3'd2;
                    8'h26: e_vec[2:0] = 3'd3;
                    8'h64: e_vec[2:0] = 3'd4;
                    8'h65: e_vec[2:0] = 3'd5;
                    8'h36: e_vec[2:0] = 3'd6;
                    8'hF2: e_vec[7] = 1'b1;
                    8'hF3: e_vec[6] = 1'b1;
                    8'hF0: e_vec[5] = 1'b1;
                    8'h67: e_vec[4] = 1'b1;
                    8'h66: e_vec[3] = 1'b1;
                    default: begin
                        if (mode == 2'd0 && b[7:4] == 4'h4) begin
                            e_rs = 1'b1; e_rex = b[3:0];
                        end else begin
                            e_op = b;
                            e_sz = exp_size(mode, e_rs & e_rex[3], e_vec[3]);
                            e_done = 1'b1; e_fin = 1'b1;
                        end
                    end
                endcase
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(pfx_vec == e_vec, {tag, " R2 R3 vec"}, pfx_vec, e_vec);
        chk(rex_seen == e_rs && rex_bits == e_rex, {tag, " R4 rex"},
            {rex_seen, rex_bits}, {e_rs, e_rex});
        chk(opcode == e_op, {tag, " R5 opcode"}, opcode, e_op);
        chk(done == e_done, {tag, " R5 done"}, done, e_done);
        chk(op_size == e_sz, {tag, " R6 R7 R8 size"}, op_size, e_sz);
    endtask

    // Called at a falling edge: drive, wait one edge, compare.
    task automatic step(input logic v, input logic [7:0] b, input logic clr,
                        input string tag);
        byte_valid = v; byte_in = b; clear = clr;
        @(negedge clk);
        model(v, b, clr);
        compare_all(tag);
        byte_valid = 1'b0; clear = 1'b0;
    endtask

    task automatic send(input logic [1:0] m, input logic [7:0] bytes[$], input string tag);
        mode = m;
        step(1'b0, 8'h00, 1'b1, {tag, " R1"});
        foreach (bytes[i]) step(1'b1, bytes[i], 1'b0, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240601));
        model(1'b0, 8'h00, 1'b1);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("reset R1");

        // R2: all flags, repeated
        send(2'd1, '{8'hF2, 8'hF3, 8'hF0, 8'h67, 8'h66, 8'hF0, 8'h90}, "flags R2");
        chk(pfx_vec == 8'hF8, "R2 packed", pfx_vec, 8'hF8);
        step(1'b0, 8'h00, 1'b0, "done drop R5");
        // R9: bytes after opcode ignored
        step(1'b1, 8'h2E, 1'b0, "post R9");
        step(1'b1, 8'hC3, 1'b0, "post R9");
        chk(opcode == 8'h90 && pfx_vec == 8'hF8, "R9 hold", opcode, 8'h90);

        // R3: each segment, last wins
        send(2'd1, '{8'h2E, 8'h3E, 8'h26, 8'h64, 8'h65, 8'h36}, "seg R3");
        chk(pfx_vec[2:0] == 3'd6, "R3 last wins", pfx_vec[2:0], 6);
        step(1'b1, 8'h8B, 1'b0, "seg R3 op");

        // R4/R6: extension W in long mode, with 0x66
        send(2'd0, '{8'h66, 8'h48, 8'h01}, "long W R6");
        chk(op_size == 2'd3, "R6 W wins", op_size, 3);
        send(2'd0, '{8'h66, 8'h44, 8'h01}, "long noW R6");
        chk(op_size == 2'd1, "R6 override", op_size, 1);
        send(2'd0, '{8'h01}, "long plain R6");
        // R4: same byte is opcode in 32-bit mode
        send(2'd1, '{8'h48, 8'h01}, "def32 R4");
        chk(opcode == 8'h48 && !rex_seen, "R4 not ext", opcode, 8'h48);
        // R7/R8
        send(2'd1, '{8'h66, 8'h05}, "def32 R7");
        send(2'd2, '{8'h05}, "def16 R8");
        send(2'd2, '{8'h66, 8'h05}, "def16 ovr R8");
        chk(op_size == 2'd2, "R8 ovr", op_size, 2);
        send(2'd3, '{8'h05}, "mode3 R8");

        // R1: clear beats byte in same cycle; R9 idle cycles
        send(2'd1, '{8'hF0}, "clr R1");
        step(1'b1, 8'h90, 1'b1, "clr prio R1");
        step(1'b0, 8'h90, 1'b0, "idle R9");

        // random instructions
        for (int n = 0; n < 400; n++) begin
            logic [1:0] m;
            int np;
            m = 2'($urandom_range(0, 3));
            mode = m;
            step(1'b0, 8'h00, 1'b1, "rnd R1");
            np = $urandom_range(0, 5);
            for (int k = 0; k < np; k++) begin
                logic [7:0] pb;
                case ($urandom_range(0, 11))
                    0: pb = 8'h2E; 1: pb = 8'h3E; 2: pb = 8'h26; 3: pb = 8'h64;
                    4: pb = 8'h65; 5: pb = 8'h36; 6: pb = 8'h66; 7: pb = 8'h67;
                    8: pb = 8'hF0; 9: pb = 8'hF3; 10: pb = 8'hF2;
                    default: pb = 8'h40 | 8'($urandom_range(0, 15));
                endcase
                if ($urandom_range(0, 3) == 0) step(1'b0, 8'hFF, 1'b0, "rnd gap R9");
                step(1'b1, pb, 1'b0, "rnd pfx");
            end
            begin
                logic [7:0] ob;
                ob = 8'($urandom_range(0, 255));
                while (is_prefix(ob, m)) ob = 8'($urandom_range(0, 255));
                step(1'b1, ob, 1'b0, "rnd op R5");
            end
            step(1'b1, 8'($urandom_range(0, 255)), 1'b0, "rnd post R9");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule